// File: doc/BRIEF.md
# Hardware Thread Context Allocator

This block serves a spawn request issued by a running thread. It looks at the status of a small set of hardware thread contexts and picks one that the requesting virtual processing element (VPE) may take over. For the chosen context it produces a set of one-cycle write strobes and values: the restart (first fetch) address, one general register write (index and value), a fresh status word, and optionally the user-local value. Part of the status word is inherited from the spawning context.

A context is taken only if four conditions all hold. It must be bound to the requester's VPE, marked as dynamically allocatable, not halted, and not already active. The lowest-numbered such context wins. When no context qualifies, the block does not write anything. Instead it raises an overflow exception and presents the exception code value 1, which the surrounding control logic writes into the VPE's exception-code field. The context status arrays come in on ports from the register storage, which also receives the strobes. The surrounding scheduler is not part of this block.

Top module: `ctx_alloc`

## Requirements
- R1: A context is eligible only when its VPE binding equals `req_vpe`, its `ctx_dynalloc` bit is 1, its `ctx_halt` bit is 0 and its `ctx_active` bit is 0; no other context is ever strobed.
- R2: Of the eligible contexts, only the lowest-numbered one is allocated. `ctx_we` is one-hot on success, and `grant_idx` holds its index.
- R3: On success, `new_restart` equals the `req_start` value of the request.
- R4: On success, `new_reg_idx` and `new_reg_data` equal `req_dst` and `req_data` of the request.
- R5: On success, `new_cu` equals `req_cu`, `new_mx` equals `req_mx`, and `new_active` is 1.
- R6: When no context is eligible, `ovf_exc` pulses, `exc_code` is 1, and `ctx_we` and `alloc_done` stay 0. `exc_code` is 0 whenever `ovf_exc` is 0.
- R7: With HAS_ULOCAL=1, on success `ulocal_we` pulses and `new_ulocal` equals `req_ulocal`.
- R8: With ALLOC_EN=0 (one context per VPE), every request ends in the overflow exception, whatever the status arrays hold.
- R9: Results appear exactly one cycle after the request, for one cycle only. Back-to-back requests are each answered. A cycle without a request produces no strobe, no done and no exception.
- R10: After reset, all strobes and pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Spawn request, one per cycle |
| req_vpe | input | VPE_W | VPE of the requesting thread |
| req_start | input | ADDR_W | Start address for the new thread |
| req_data | input | DATA_W | Value for the new thread's register |
| req_dst | input | REG_W | Register index in the new thread |
| req_cu | input | 4 | Requester's coprocessor-usable bits |
| req_mx | input | 1 | Requester's MX-enable bit |
| req_ulocal | input | DATA_W | Requester's user-local value |
| ctx_vpe | input | NUM_CTX*VPE_W | VPE binding per context, context k at bits k*VPE_W |
| ctx_dynalloc | input | NUM_CTX | Dynamically-allocatable flag per context |
| ctx_halt | input | NUM_CTX | Halt flag per context |
| ctx_active | input | NUM_CTX | Activated flag per context |
| ctx_we | output | NUM_CTX | One-hot write strobe to the chosen context |
| grant_idx | output | IDX_W | Index of the chosen context |
| new_restart | output | ADDR_W | Restart address to write |
| new_reg_idx | output | REG_W | Register index to write |
| new_reg_data | output | DATA_W | Register value to write |
| new_cu | output | 4 | Coprocessor-usable bits of the new status |
| new_mx | output | 1 | MX-enable bit of the new status |
| new_active | output | 1 | Activated bit of the new status |
| ulocal_we | output | 1 | User-local write strobe |
| new_ulocal | output | DATA_W | User-local value to write |
| alloc_done | output | 1 | Allocation succeeded pulse |
| ovf_exc | output | 1 | Overflow thread exception pulse |
| exc_code | output | EXC_W | Exception code (1 = overflow) |

## Verification
The bench builds the allocator with NUM_CTX=4 and NUM_VPE=2. At that size each context has one binding bit and three flags, so 16 bits describe the whole status array. Together with the requester's VPE bit, that gives 2^17 requests, and the bench issues every one of them back to back. This covers every mix of eligible and ineligible contexts in every position, and all the priority and overflow outcomes. A second copy with ALLOC_EN=0 is driven with the same stimulus to confirm that the single-context variant always ends in overflow.

// File: rtl/ctx_alloc_pkg.sv
package ctx_alloc_pkg;

  localparam int CU_W = 4;
  localparam int OVERFLOW_CODE = 1;

  typedef struct packed {
    logic [CU_W-1:0] cu;
    logic            mx;
    logic            active;
  } new_status_t;

  // Four-way eligibility test for one context.
  function automatic logic ctx_eligible(input logic vpe_match, input logic dynalloc,
                                        input logic halted, input logic active);
    return vpe_match & dynalloc & ~halted & ~active;
  endfunction

  // Status of the spawned context: inherited fields plus the activated bit.
  function automatic new_status_t build_status(input logic [CU_W-1:0] cu, input logic mx);
    new_status_t s;
    s.cu     = cu;
    s.mx     = mx;
    s.active = 1'b1;
    return s;
  endfunction

endpackage

// File: rtl/ctx_elig_vec.sv
module ctx_elig_vec #(
  parameter int NUM_CTX = 8,
  parameter int VPE_W   = 1
) (
  input  logic [VPE_W-1:0]         req_vpe,
  input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
  input  logic [NUM_CTX-1:0]       ctx_dynalloc,
  input  logic [NUM_CTX-1:0]       ctx_halt,
  input  logic [NUM_CTX-1:0]       ctx_active,
  output logic [NUM_CTX-1:0]       elig
);
  import ctx_alloc_pkg::*;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic vpe_match;
    assign vpe_match = (ctx_vpe[g*VPE_W +: VPE_W] == req_vpe);
    assign elig[g]   = ctx_eligible(vpe_match, ctx_dynalloc[g], ctx_halt[g], ctx_active[g]);
  end

endmodule

// File: rtl/ctx_low_pick.sv
module ctx_low_pick #(
  parameter int NUM_CTX = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_CTX-1:0] cand,
  output logic [NUM_CTX-1:0] pick_vec,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               pick_any
);

  // Ascending scan: first hit is kept, later hits are ignored.
  always_comb begin
    pick_vec = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (cand[k] && !pick_any) begin
        pick_vec[k] = 1'b1;
        pick_idx    = IDX_W'(k);
        pick_any    = 1'b1;
      end
    end
  end

  always_comb begin
    assert_pick_onehot_R2: assert ($onehot0(pick_vec))
      else $error("picker produced more than one grant");
    assert_pick_subset_R1: assert ((pick_vec & ~cand) == '0)
      else $error("picker granted a non-candidate");
  end

endmodule

// File: rtl/ctx_alloc.sv
module ctx_alloc #(
  parameter int NUM_CTX    = 8,
  parameter int NUM_VPE    = 2,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int REG_W      = 5,
  parameter int EXC_W      = 3,
  parameter bit ALLOC_EN   = 1'b1,
  parameter bit HAS_ULOCAL = 1'b1,
  localparam int VPE_W     = (NUM_VPE > 1) ? $clog2(NUM_VPE) : 1,
  localparam int IDX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     spawn_req,
  input  logic [VPE_W-1:0]         req_vpe,
  input  logic [ADDR_W-1:0]        req_start,
  input  logic [DATA_W-1:0]        req_data,
  input  logic [REG_W-1:0]         req_dst,
  input  logic [3:0]               req_cu,
  input  logic                     req_mx,
  input  logic [DATA_W-1:0]        req_ulocal,
  input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
  input  logic [NUM_CTX-1:0]       ctx_dynalloc,
  input  logic [NUM_CTX-1:0]       ctx_halt,
  input  logic [NUM_CTX-1:0]       ctx_active,
  output logic [NUM_CTX-1:0]       ctx_we,
  output logic [IDX_W-1:0]         grant_idx,
  output logic [ADDR_W-1:0]        new_restart,
  output logic [REG_W-1:0]         new_reg_idx,
  output logic [DATA_W-1:0]        new_reg_data,
  output logic [3:0]               new_cu,
  output logic                     new_mx,
  output logic                     new_active,
  output logic                     ulocal_we,
  output logic [DATA_W-1:0]        new_ulocal,
  output logic                     alloc_done,
  output logic                     ovf_exc,
  output logic [EXC_W-1:0]         exc_code
);
  import ctx_alloc_pkg::*;

  // Named internal events.
  logic [NUM_CTX-1:0] elig_raw;
  logic [NUM_CTX-1:0] elig_eff;
  logic [NUM_CTX-1:0] pick_vec;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_any;
  logic               grant_evt;
  logic               ovf_evt;
  new_status_t        stat_next;

  ctx_elig_vec #(.NUM_CTX(NUM_CTX), .VPE_W(VPE_W)) u_elig (
    .req_vpe     (req_vpe),
    .ctx_vpe     (ctx_vpe),
    .ctx_dynalloc(ctx_dynalloc),
    .ctx_halt    (ctx_halt),
    .ctx_active  (ctx_active),
    .elig        (elig_raw)
  );

  // Single-context-per-VPE variant: nothing is ever eligible.
  if (ALLOC_EN) begin : g_alloc
    assign elig_eff = elig_raw;
  end else begin : g_ovf_only
    assign elig_eff = elig_raw & '0;
  end

  ctx_low_pick #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) u_pick (
    .cand    (elig_eff),
    .pick_vec(pick_vec),
    .pick_idx(pick_idx),
    .pick_any(pick_any)
  );

  assign grant_evt = spawn_req & pick_any;
  assign ovf_evt   = spawn_req & ~pick_any;
  assign stat_next = build_status(req_cu, req_mx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_we       <= '0;
      grant_idx    <= '0;
      new_restart  <= '0;
      new_reg_idx  <= '0;
      new_reg_data <= '0;
      new_cu       <= '0;
      new_mx       <= 1'b0;
      new_active   <= 1'b0;
      ulocal_we    <= 1'b0;
      new_ulocal   <= '0;
      alloc_done   <= 1'b0;
      ovf_exc      <= 1'b0;
      exc_code     <= '0;
    end else begin
      ctx_we     <= grant_evt ? pick_vec : '0;
      alloc_done <= grant_evt;
      ovf_exc    <= ovf_evt;
      exc_code   <= ovf_evt ? EXC_W'(OVERFLOW_CODE) : '0;
      ulocal_we  <= grant_evt & HAS_ULOCAL;
      if (grant_evt) begin
        grant_idx    <= pick_idx;
        new_restart  <= req_start;
        new_reg_idx  <= req_dst;
        new_reg_data <= req_data;
        new_cu       <= stat_next.cu;
        new_mx       <= stat_next.mx;
        new_active   <= stat_next.active;
        new_ulocal   <= HAS_ULOCAL ? req_ulocal : '0;
      end
    end
  end

  assert_strobe_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> $onehot(ctx_we));
  assert_no_strobe_on_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_exc |-> (ctx_we == '0) && !alloc_done);
  assert_pick_not_halted_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_vec & (ctx_halt | ctx_active)) == '0);
  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !spawn_req |=> !alloc_done && !ovf_exc && (ctx_we == '0));
  assert_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_req |=> (alloc_done ^ ovf_exc));
  assert_active_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> new_active);
  assert_ovf_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ALLOC_EN |-> !alloc_done);

endmodule

// File: tb/ctx_alloc_tb.sv
module ctx_alloc_tb;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          spawn_req = 1'b0;
  logic [0:0]    req_vpe = '0;
  logic [31:0]   req_start = '0, req_data = '0, req_ulocal = '0;
  logic [4:0]    req_dst = '0;
  logic [3:0]    req_cu = '0;
  logic          req_mx = 1'b0;
  logic [NC-1:0] ctx_vpe = '0, ctx_dynalloc = '0, ctx_halt = '0, ctx_active = '0;

  logic [NC-1:0] ctx_we, s_ctx_we;
  logic [1:0]    grant_idx, s_grant_idx;
  logic [31:0]   new_restart, new_reg_data, new_ulocal, s_restart, s_reg_data, s_ulocal;
  logic [4:0]    new_reg_idx, s_reg_idx;
  logic [3:0]    new_cu, s_cu;
  logic          new_mx, new_active, ulocal_we, alloc_done, ovf_exc;
  logic          s_mx, s_active, s_ulocal_we, s_done, s_ovf;
  logic [2:0]    exc_code, s_exc_code;

  ctx_alloc #(.NUM_CTX(NC), .NUM_VPE(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .req_vpe(req_vpe),
    .req_start(req_start), .req_data(req_data), .req_dst(req_dst), .req_cu(req_cu),
    .req_mx(req_mx), .req_ulocal(req_ulocal), .ctx_vpe(ctx_vpe),
    .ctx_dynalloc(ctx_dynalloc), .ctx_halt(ctx_halt), .ctx_active(ctx_active),
    .ctx_we(ctx_we), .grant_idx(grant_idx), .new_restart(new_restart),
    .new_reg_idx(new_reg_idx), .new_reg_data(new_reg_data), .new_cu(new_cu),
    .new_mx(new_mx), .new_active(new_active), .ulocal_we(ulocal_we),
    .new_ulocal(new_ulocal), .alloc_done(alloc_done), .ovf_exc(ovf_exc),
    .exc_code(exc_code));

  ctx_alloc #(.NUM_CTX(NC), .NUM_VPE(2), .ALLOC_EN(1'b0)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .req_vpe(req_vpe),
    .req_start(req_start), .req_data(req_data), .req_dst(req_dst), .req_cu(req_cu),
    .req_mx(req_mx), .req_ulocal(req_ulocal), .ctx_vpe(ctx_vpe),
    .ctx_dynalloc(ctx_dynalloc), .ctx_halt(ctx_halt), .ctx_active(ctx_active),
    .ctx_we(s_ctx_we), .grant_idx(s_grant_idx), .new_restart(s_restart),
    .new_reg_idx(s_reg_idx), .new_reg_data(s_reg_data), .new_cu(s_cu),
    .new_mx(s_mx), .new_active(s_active), .ulocal_we(s_ulocal_we),
    .new_ulocal(s_ulocal), .alloc_done(s_done), .ovf_exc(s_ovf),
    .exc_code(s_exc_code));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Stimulus derived from a 17-bit sweep value: bits 4k..4k+3 describe context k
  // (binding, allocatable, halted, active); bit 16 is the requester's VPE.
  task automatic apply(input logic [16:0] p);
    for (int k = 0; k < NC; k++) begin
      ctx_vpe[k]      = p[4*k];
      ctx_dynalloc[k] = p[4*k+1];
      ctx_halt[k]     = p[4*k+2];
      ctx_active[k]   = p[4*k+3];
    end
    req_vpe    = p[16];
    req_start  = {15'h1abc, p};
    req_data   = ~{p, 15'h0f0f};
    req_ulocal = {p[7:0], 7'h33, p};
    req_dst    = p[4:0] ^ p[12:8];
    req_cu     = p[3:0] ^ p[15:12];
    req_mx     = p[5] ^ p[16];
  endtask

  logic [16:0]   e_p;
  bit            e_valid = 1'b0;

  task automatic verify(input logic [16:0] p);
    logic [NC-1:0] exp_we = '0;
    int exp_idx = 0;
    bit found = 1'b0;
    for (int k = 0; k < NC; k++) begin
      bit ok = (p[4*k] == p[16]) && p[4*k+1] && !p[4*k+2] && !p[4*k+3];
      if (ok && !found) begin
        found = 1'b1;
        exp_we[k] = 1'b1;
        exp_idx = k;
      end
    end
    check(ctx_we == exp_we, "R1/R2 strobe", 32'(ctx_we), 32'(exp_we));
    check(alloc_done == found, "R9 done", 32'(alloc_done), 32'(found));
    check(ovf_exc == !found, "R6 overflow", 32'(ovf_exc), 32'(!found));
    check(exc_code == (found ? 3'd0 : 3'd1), "R6 code", 32'(exc_code), found ? 0 : 1);
    check(s_ovf && !s_done && s_ctx_we == '0, "R8 single", 32'(s_ovf), 1);
    if (found) begin
      check(grant_idx == exp_idx[1:0], "R2 index", 32'(grant_idx), 32'(exp_idx));
      check(new_restart == {15'h1abc, p}, "R3 restart", new_restart, {15'h1abc, p});
      check(new_reg_idx == (p[4:0] ^ p[12:8]) && new_reg_data == ~{p, 15'h0f0f},
            "R4 register", new_reg_data, ~{p, 15'h0f0f});
      check(new_cu == (p[3:0] ^ p[15:12]) && new_mx == (p[5] ^ p[16]) && new_active,
            "R5 status", {new_cu, new_mx, new_active},
            {(p[3:0] ^ p[15:12]), (p[5] ^ p[16]), 1'b1});
      check(ulocal_we && new_ulocal == {p[7:0], 7'h33, p}, "R7 ulocal", new_ulocal,
            {p[7:0], 7'h33, p});
    end else begin
      check(!ulocal_we, "R7 no ulocal", 32'(ulocal_we), 0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ctx_we == '0 && !alloc_done && !ovf_exc && !ulocal_we && exc_code == '0,
          "R10 reset", {ctx_we, alloc_done, ovf_exc, ulocal_we}, 0);
    rst_n = 1'b1;
    // R9: all contexts free but no request -> nothing happens
    apply(17'h02222);
    repeat (3) begin
      @(negedge clk);
      check(ctx_we == '0 && !alloc_done && !ovf_exc, "R9 idle",
            {ctx_we, alloc_done, ovf_exc}, 0);
    end
    // Exhaustive back-to-back sweep (R1-R8)
    for (int i = 0; i < (1 << 17); i++) begin
      apply(17'(i));
      spawn_req = 1'b1;
      @(negedge clk);
      if (e_valid) begin end
      verify(17'(i));
    end
    // Sweep above checks each result one cycle later only; verify pulse ends (R9)
    spawn_req = 1'b0;
    @(negedge clk);
    check(!alloc_done && !ovf_exc && ctx_we == '0, "R9 pulse ends",
          {alloc_done, ovf_exc}, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule